// File: doc/BRIEF.md
# Power Domain Gating Sequencer

This block controls power gating of one switchable logic domain and holds the gating settings for a second, processor domain. Software programs it over a simple register bus. A write to the control register posts a power-down or a power-up request. The sequencer then steps the domain's isolation and power-switch outputs in a fixed order. It waits a programmed number of bus-clock cycles between the steps, and clears the request bit when the sequence completes.

Each domain has three registers: a gate-enable register and two timing registers. The power-up timing register holds the switch delay and the switch-to-isolation delay. The power-down timing register holds the isolation delay and the isolation-to-switch delay. The processor domain's registers are stored and driven out on dedicated ports for a neighbouring controller. A busy flag is visible both on a port and in the control register.

Top module: `pgate_seq`

## Requirements
- R1: After reset, iso_o, pwr_off_o and busy_o are 0, and every register reads 0.
- R2: Register map. Control is at 0x000: bit 0 is the power-down request, bit 1 is the power-up request and bit 31 is busy. The switchable domain has its gate enable at 0x260 (bit 0), its power-up timing at 0x264 and its power-down timing at 0x268. The processor domain uses 0x2A0, 0x2A4 and 0x2A8. Timing registers keep only bits [13:8] and [5:0]. Unmapped addresses read 0. The processor-domain fields appear on the cpu_* ports.
- R3: Power-down. The request is written at clock edge E0. Power-down timing bits [5:0] give a and bits [13:8] give b. iso_o rises at edge E0+1, pwr_off_o rises at E0+1+a, and the sequence ends at E0+1+a+b.
- R4: Power-up. The request is written at E0. Power-up timing bits [5:0] give c and bits [13:8] give d. pwr_off_o falls at E0+1, and iso_o falls at E0+1+c+d, where the sequence ends.
- R5: A delay field of zero counts as a one-cycle step.
- R6: When gate-enable bit 0 is 0, a power-down request leaves iso_o and pwr_off_o unchanged and is cleared at E0+1.
- R7: When both request bits are written together, power-up runs and the power-down request is discarded.
- R8: A request written while a sequence runs is held. It starts one edge after the running sequence ends.
- R9: busy_o and control bit 31 are 1 while a request is pending or a sequence runs. A request bit clears itself when its sequence ends. Writing 0 to a request bit has no effect.
- R10: iso_o is 1 whenever pwr_off_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Bus access strobe |
| bus_write_i | input | 1 | Access is a write |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address |
| iso_o | output | 1 | Isolation of the switchable domain |
| pwr_off_o | output | 1 | Power switch open (domain unpowered) |
| busy_o | output | 1 | Request pending or sequence running |
| cpu_gate_en_o | output | 1 | Processor domain gate enable |
| cpu_pu_sw_dly_o | output | 6 | Processor power-up switch delay |
| cpu_pu_iso_dly_o | output | 6 | Processor power-up switch-to-isolation delay |
| cpu_pd_iso_dly_o | output | 6 | Processor power-down isolation delay |
| cpu_pd_sw_dly_o | output | 6 | Processor power-down isolation-to-switch delay |

## Verification
The hardest situation to reach is a request that collides with a running sequence. The second write has to land exactly on the first edge of a power-down, before that sequence has advanced. The stimulus issues the power-up write on the cycle right after the power-down write. The expected timeline therefore chains both delay sums plus the one-edge restart. A same-write collision of both request bits is also driven. After it, the outputs are watched past the point where a wrongly kept power-down would have raised isolation.

// File: rtl/pgate_pkg.sv
package pgate_pkg;
  localparam int DLY_W      = 6;
  localparam int HI_SHIFT   = 8;
  localparam int PD_BIT     = 0;
  localparam int PU_BIT     = 1;
  localparam int BUSY_BIT   = 31;
  localparam int OFF_CTRL   = 'h000;
  localparam int DOM_BASE0  = 'h260;
  localparam int DOM_STRIDE = 'h040;
  localparam int OFF_GATE   = 'h0;
  localparam int OFF_PU     = 'h4;
  localparam int OFF_PD     = 'h8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PD_ISO, ST_PD_SW, ST_PU_SW, ST_PU_ISO
  } seq_state_e;

  typedef struct packed {
    logic             gate_en;
    logic [DLY_W-1:0] pu_sw;
    logic [DLY_W-1:0] pu_s2i;
    logic [DLY_W-1:0] pd_iso;
    logic [DLY_W-1:0] pd_i2s;
  } dom_cfg_t;
endpackage

// File: rtl/pgate_dly_cnt.sv
module pgate_dly_cnt #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  // a step lasts max(val,1) cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= (val_i == '0) ? '0 : val_i - W'(1);
    else if (cnt_q != '0)       cnt_q <= cnt_q - W'(1);
  end

  assign done_o = (cnt_q == '0);

  assert_zero_one_cycle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && val_i == '0) |=> done_o);
endmodule

// File: rtl/pgate_fsm.sv
module pgate_fsm import pgate_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_pend_i,
  input  logic             pu_pend_i,
  input  dom_cfg_t         cfg_i,
  input  logic             cnt_done_i,
  output logic             cnt_load_o,
  output logic [DLY_W-1:0] cnt_val_o,
  output logic             clr_pd_o,
  output logic             clr_pu_o,
  output logic             active_o,
  output logic             iso_o,
  output logic             pwr_off_o
);
  seq_state_e state_q, state_d;
  logic iso_q, off_q;

  always_comb begin
    state_d    = state_q;
    cnt_load_o = 1'b0;
    cnt_val_o  = '0;
    clr_pd_o   = 1'b0;
    clr_pu_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (pu_pend_i) begin
          state_d    = ST_PU_SW;
          cnt_load_o = 1'b1;
          cnt_val_o  = cfg_i.pu_sw;
          clr_pd_o   = pd_pend_i;  // power-up wins, loser dropped
        end else if (pd_pend_i) begin
          if (cfg_i.gate_en) begin
            state_d    = ST_PD_ISO;
            cnt_load_o = 1'b1;
            cnt_val_o  = cfg_i.pd_iso;
          end else begin
            clr_pd_o = 1'b1;
          end
        end
      end
      ST_PD_ISO: if (cnt_done_i) begin
        state_d    = ST_PD_SW;
        cnt_load_o = 1'b1;
        cnt_val_o  = cfg_i.pd_i2s;
      end
      ST_PD_SW: if (cnt_done_i) begin
        state_d  = ST_IDLE;
        clr_pd_o = 1'b1;
      end
      ST_PU_SW: if (cnt_done_i) begin
        state_d    = ST_PU_ISO;
        cnt_load_o = 1'b1;
        cnt_val_o  = cfg_i.pu_s2i;
      end
      ST_PU_ISO: if (cnt_done_i) begin
        state_d  = ST_IDLE;
        clr_pu_o = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      iso_q   <= 1'b0;
      off_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && state_d == ST_PD_ISO)      iso_q <= 1'b1;
      else if (state_q == ST_PU_ISO && cnt_done_i)         iso_q <= 1'b0;
      if (state_q == ST_PD_ISO && cnt_done_i)              off_q <= 1'b1;
      else if (state_q == ST_IDLE && state_d == ST_PU_SW)  off_q <= 1'b0;
    end
  end

  assign active_o  = (state_q != ST_IDLE);
  assign iso_o     = iso_q;
  assign pwr_off_o = off_q;

  assert_iso_covers_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_q |-> iso_q);
  assert_off_after_iso_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(off_q) |-> $past(iso_q));
  assert_iso_release_after_on_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(iso_q) |-> !$past(off_q));
  assert_gate_blocks_pd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && pd_pend_i && !pu_pend_i && !cfg_i.gate_en)
      |=> (state_q == ST_IDLE && $stable(iso_q) && $stable(off_q)));
  assert_pu_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && pd_pend_i && pu_pend_i) |=> (state_q == ST_PU_SW));
endmodule

// File: rtl/pgate_regs.sv
module pgate_regs import pgate_pkg::*; #(
  parameter int N_DOM  = 2,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              active_i,
  input  logic              clr_pd_i,
  input  logic              clr_pu_i,
  output logic              pd_pend_o,
  output logic              pu_pend_o,
  output logic              busy_o,
  output dom_cfg_t          cfg_o [N_DOM]
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);

  logic wr;
  logic pd_q, pu_q;
  logic [DATA_W-1:0] dom_rd [N_DOM];
  logic [N_DOM-1:0]  dom_hit;
  logic unused_wdata;

  assign wr = bus_valid_i & bus_write_i;
  assign unused_wdata = ^{bus_wdata_i[DATA_W-1:HI_SHIFT+DLY_W], bus_wdata_i[HI_SHIFT-1:DLY_W]};

  // write-one-to-set; a new set beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_q <= 1'b0;
      pu_q <= 1'b0;
    end else begin
      if (wr && bus_addr_i == A_CTRL && bus_wdata_i[PD_BIT]) pd_q <= 1'b1;
      else if (clr_pd_i)                                     pd_q <= 1'b0;
      if (wr && bus_addr_i == A_CTRL && bus_wdata_i[PU_BIT]) pu_q <= 1'b1;
      else if (clr_pu_i)                                     pu_q <= 1'b0;
    end
  end

  assign pd_pend_o = pd_q;
  assign pu_pend_o = pu_q;
  assign busy_o    = active_i | pd_q | pu_q;

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    localparam logic [ADDR_W-1:0] A_GATE = ADDR_W'(DOM_BASE0 + d * DOM_STRIDE + OFF_GATE);
    localparam logic [ADDR_W-1:0] A_PU   = ADDR_W'(DOM_BASE0 + d * DOM_STRIDE + OFF_PU);
    localparam logic [ADDR_W-1:0] A_PD   = ADDR_W'(DOM_BASE0 + d * DOM_STRIDE + OFF_PD);

    logic             gate_q;
    logic [DLY_W-1:0] pu_lo_q, pu_hi_q, pd_lo_q, pd_hi_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        gate_q  <= 1'b0;
        pu_lo_q <= '0;
        pu_hi_q <= '0;
        pd_lo_q <= '0;
        pd_hi_q <= '0;
      end else if (wr) begin
        if (bus_addr_i == A_GATE) gate_q <= bus_wdata_i[0];
        if (bus_addr_i == A_PU) begin
          pu_lo_q <= bus_wdata_i[DLY_W-1:0];
          pu_hi_q <= bus_wdata_i[HI_SHIFT+DLY_W-1:HI_SHIFT];
        end
        if (bus_addr_i == A_PD) begin
          pd_lo_q <= bus_wdata_i[DLY_W-1:0];
          pd_hi_q <= bus_wdata_i[HI_SHIFT+DLY_W-1:HI_SHIFT];
        end
      end
    end

    assign cfg_o[d] = '{gate_en: gate_q, pu_sw: pu_lo_q, pu_s2i: pu_hi_q,
                        pd_iso: pd_lo_q, pd_i2s: pd_hi_q};

    always_comb begin
      dom_hit[d] = 1'b1;
      dom_rd[d]  = '0;
      if (bus_addr_i == A_GATE)    dom_rd[d][0] = gate_q;
      else if (bus_addr_i == A_PU) begin
        dom_rd[d][DLY_W-1:0]                 = pu_lo_q;
        dom_rd[d][HI_SHIFT+DLY_W-1:HI_SHIFT] = pu_hi_q;
      end else if (bus_addr_i == A_PD) begin
        dom_rd[d][DLY_W-1:0]                 = pd_lo_q;
        dom_rd[d][HI_SHIFT+DLY_W-1:HI_SHIFT] = pd_hi_q;
      end else dom_hit[d] = 1'b0;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == A_CTRL) begin
      bus_rdata_o[PD_BIT]   = pd_q;
      bus_rdata_o[PU_BIT]   = pu_q;
      bus_rdata_o[BUSY_BIT] = busy_o;
    end
    for (int d = 0; d < N_DOM; d++)
      if (dom_hit[d]) bus_rdata_o = dom_rd[d];
  end

  assert_req_clears_when_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_pd_i && !(wr && bus_addr_i == A_CTRL && bus_wdata_i[PD_BIT])) |=> !pd_q);
  assert_busy_while_pending_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_q || pu_q) |-> busy_o);
endmodule

// File: rtl/pgate_seq.sv
module pgate_seq import pgate_pkg::*; #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              iso_o,
  output logic              pwr_off_o,
  output logic              busy_o,
  output logic              cpu_gate_en_o,
  output logic [DLY_W-1:0]  cpu_pu_sw_dly_o,
  output logic [DLY_W-1:0]  cpu_pu_iso_dly_o,
  output logic [DLY_W-1:0]  cpu_pd_iso_dly_o,
  output logic [DLY_W-1:0]  cpu_pd_sw_dly_o
);
  localparam int N_DOM   = 2;
  localparam int DOM_SW  = 0;
  localparam int DOM_CPU = 1;

  dom_cfg_t         cfg [N_DOM];
  logic             pd_pend, pu_pend, clr_pd, clr_pu, active;
  logic             cnt_load, cnt_done;
  logic [DLY_W-1:0] cnt_val;

  pgate_regs #(.N_DOM(N_DOM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .bus_valid_i, .bus_write_i, .bus_addr_i, .bus_wdata_i,
    .bus_rdata_o, .active_i(active), .clr_pd_i(clr_pd), .clr_pu_i(clr_pu),
    .pd_pend_o(pd_pend), .pu_pend_o(pu_pend), .busy_o, .cfg_o(cfg)
  );

  pgate_fsm u_fsm (
    .clk_i, .rst_ni, .pd_pend_i(pd_pend), .pu_pend_i(pu_pend),
    .cfg_i(cfg[DOM_SW]), .cnt_done_i(cnt_done), .cnt_load_o(cnt_load),
    .cnt_val_o(cnt_val), .clr_pd_o(clr_pd), .clr_pu_o(clr_pu),
    .active_o(active), .iso_o, .pwr_off_o
  );

  pgate_dly_cnt #(.W(DLY_W)) u_cnt (
    .clk_i, .rst_ni, .load_i(cnt_load), .val_i(cnt_val), .done_o(cnt_done)
  );

  assign cpu_gate_en_o    = cfg[DOM_CPU].gate_en;
  assign cpu_pu_sw_dly_o  = cfg[DOM_CPU].pu_sw;
  assign cpu_pu_iso_dly_o = cfg[DOM_CPU].pu_s2i;
  assign cpu_pd_iso_dly_o = cfg[DOM_CPU].pd_iso;
  assign cpu_pd_sw_dly_o  = cfg[DOM_CPU].pd_i2s;
endmodule

// File: tb/pgate_seq_tb.sv
module pgate_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        iso, pwr_off, busy, cpu_gate_en;
  logic [5:0]  cpu_pu_sw, cpu_pu_iso, cpu_pd_iso, cpu_pd_sw;

  int checks = 0, errors = 0, pcyc = 0;

  typedef struct {
    int    cyc;
    bit    iso, off, busy;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) pcyc <= pcyc + 1;

  pgate_seq u_dut (
    .clk_i(clk), .rst_ni, .bus_valid_i(bus_valid), .bus_write_i(bus_write),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .iso_o(iso), .pwr_off_o(pwr_off), .busy_o(busy), .cpu_gate_en_o(cpu_gate_en),
    .cpu_pu_sw_dly_o(cpu_pu_sw), .cpu_pu_iso_dly_o(cpu_pu_iso),
    .cpu_pd_iso_dly_o(cpu_pd_iso), .cpu_pd_sw_dly_o(cpu_pd_sw)
  );

  // monitor: compare expected output samples at their cycle
  always @(negedge clk) begin
    while (exp_q.size() != 0 && exp_q[0].cyc <= pcyc) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (e.cyc != pcyc || iso !== e.iso || pwr_off !== e.off || busy !== e.busy) begin
        errors++;
        $display("FAIL %s cyc %0d: iso/off/busy actual %b%b%b expected %b%b%b",
                 e.tag, e.cyc, iso, pwr_off, busy, e.iso, e.off, e.busy);
      end
    end
  end

  function automatic int eff(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  task automatic push(input int c, input bit i, input bit o, input bit b, input string t);
    exp_t e;
    e.cyc = c; e.iso = i; e.off = o; e.busy = b; e.tag = t;
    exp_q.push_back(e);
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] expv, input string t);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, act, expv);
    end
  endtask

  task automatic chk_rd(input logic [11:0] a, input logic [31:0] expv, input string t);
    bus_addr = a;
    #1;
    chk(bus_rdata, expv, t);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // power-down from powered state
  task automatic run_pd(input int ia, input int ib, input string t);
    int p, a, b;
    bus_wr(12'h268, 32'((ib << 8) | ia));
    a = eff(ia); b = eff(ib); p = pcyc;
    push(p+1, 0, 0, 1, t); push(p+2, 1, 0, 1, t);
    push(p+1+a, 1, 0, 1, t); push(p+2+a, 1, 1, 1, t);
    push(p+1+a+b, 1, 1, 1, t); push(p+2+a+b, 1, 1, 0, t);
    bus_wr(12'h000, 32'h1);
    chk_rd(12'h000, 32'h8000_0001, {t, " busy/req bits R9"});
    drain();
    chk_rd(12'h000, 32'h0, {t, " self clear R9"});
  endtask

  // power-up from unpowered state
  task automatic run_pu(input int ic, input int id, input string t);
    int p, c, d;
    bus_wr(12'h264, 32'((id << 8) | ic));
    c = eff(ic); d = eff(id); p = pcyc;
    push(p+1, 1, 1, 1, t); push(p+2, 1, 0, 1, t);
    push(p+1+c+d, 1, 0, 1, t); push(p+2+c+d, 0, 0, 0, t);
    bus_wr(12'h000, 32'h2);
    drain();
    chk_rd(12'h000, 32'h0, {t, " self clear R9"});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk({29'b0, iso, pwr_off, busy}, 32'h0, "R1 outputs");
    chk_rd(12'h000, 32'h0, "R1 ctrl");
    chk_rd(12'h260, 32'h0, "R1 gate");
    chk_rd(12'h264, 32'h0, "R1 pu timing");
    chk_rd(12'h2A8, 32'h0, "R1 cpu pd timing");

    // R2 register map and masking
    bus_wr(12'h264, 32'hFFFF_FFFF); chk_rd(12'h264, 32'h0000_3F3F, "R2 pu mask");
    bus_wr(12'h268, 32'h1234_5678); chk_rd(12'h268, 32'h0000_1638, "R2 pd mask");
    bus_wr(12'h260, 32'hFFFF_FFFE); chk_rd(12'h260, 32'h0, "R2 gate bit0 only");
    bus_wr(12'h2A0, 32'h5);         chk_rd(12'h2A0, 32'h1, "R2 cpu gate");
    bus_wr(12'h2A4, 32'h0A0B);      chk_rd(12'h2A4, 32'h0A0B, "R2 cpu pu");
    bus_wr(12'h2A8, 32'h2122);      chk_rd(12'h2A8, 32'h2122, "R2 cpu pd");
    chk({7'b0, cpu_gate_en, cpu_pu_sw, cpu_pu_iso, cpu_pd_iso, cpu_pd_sw},
        {7'b0, 1'b1, 6'h0B, 6'h0A, 6'h22, 6'h21}, "R2 cpu ports");
    chk_rd(12'h26C, 32'h0, "R2 unmapped");
    bus_wr(12'h000, 32'h0);
    chk_rd(12'h000, 32'h0, "R9 write zero no effect");
    chk({31'b0, busy}, 32'h0, "R9 idle after zero write");

    // R6 gate disabled: power-down request has no effect
    begin
      int p;
      bus_wr(12'h268, 32'h0203);
      p = pcyc;
      push(p+1, 0, 0, 1, "R6"); push(p+2, 0, 0, 0, "R6"); push(p+5, 0, 0, 0, "R6");
      bus_wr(12'h000, 32'h1);
      drain();
      chk_rd(12'h000, 32'h0, "R6 request cleared");
    end

    bus_wr(12'h260, 32'h1);
    run_pd(3, 2, "R3 pd");
    run_pu(2, 4, "R4 pu");
    run_pd(0, 0, "R5 pd zero");
    run_pu(0, 0, "R5 pu zero");

    // R7 both bits in one write while powered
    begin
      int p;
      bus_wr(12'h264, 32'h0103);
      p = pcyc;
      push(p+1, 0, 0, 1, "R7"); push(p+2, 0, 0, 1, "R7");
      push(p+5, 0, 0, 1, "R7"); push(p+6, 0, 0, 0, "R7");
      push(p+7, 0, 0, 0, "R7"); push(p+9, 0, 0, 0, "R7");
      bus_wr(12'h000, 32'h3);
      drain();
      chk_rd(12'h000, 32'h0, "R7 power-down dropped");
    end

    // R8 power-up held behind running power-down
    begin
      int p;
      bus_wr(12'h268, 32'h0203);
      bus_wr(12'h264, 32'h0201);
      p = pcyc;
      push(p+1, 0, 0, 1, "R8"); push(p+2, 1, 0, 1, "R8");
      push(p+5, 1, 1, 1, "R8"); push(p+7, 1, 1, 1, "R8");
      push(p+8, 1, 0, 1, "R8"); push(p+10, 1, 0, 1, "R8");
      push(p+11, 0, 0, 0, "R8");
      bus_wr(12'h000, 32'h1);
      bus_wr(12'h000, 32'h2);
      chk_rd(12'h000, 32'h8000_0003, "R8 both pending");
      drain();
      chk_rd(12'h000, 32'h0, "R8 all cleared");
    end

    // R10 is covered by every timeline above; final idle state
    chk({30'b0, iso, pwr_off}, 32'h0, "R10 final powered");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule